// File: doc/BRIEF.md
# Merged Codeword Lookup

This block decodes one variable-length codeword from the head of a bit window. It serves three logical code tables but holds only one copy of the codewords they all share. The window is six bits wide and left-aligned: bit 5 is the first bit of the stream. A two-bit select names the active table.

The six codewords that every table contains are matched once, in a common section. That section gives the codeword length and a position index from 0 to 5. Each table also has two codewords of its own, held in a small private section. Only the section of the selected table takes part, and its entries take indices 6 and 7. The index and the select together form a five-bit code value, so the same codeword can stand for a different symbol in each table while its length stays the same.

The length output is the figure a stream parser needs in order to advance to the next codeword, so it must be exact. The lookup is purely combinational and has no clock, which lets it sit inside a single-cycle decode step.

Top module: `merged_cw_lookup`

## Requirements
- R1: For select 0, 1 or 2, the common codewords decode with hit=1 to these (index, length) pairs: 111 gives (0,3), 110 gives (1,3), 0101 gives (2,4), 0100 gives (3,4), 00011 gives (4,5) and 00010 gives (5,5). Codewords are read from window bit 5 downward.
- R2: With select 0, codeword 000011 decodes to index 6 and length 6, and 000001 decodes to index 7 and length 6.
- R3: With select 1, codeword 00001 decodes to index 6 and length 5, and 000000 decodes to index 7 and length 6.
- R4: With select 2, codeword 00000 decodes to index 6 and length 5, and 00001 decodes to index 7 and length 5.
- R5: Window bits below the matched length have no effect on any output.
- R6: When no entry of the selected table matches, hit is 0 and the length, index and code outputs are all 0. For example, 000010 misses in table 0, and 000001 misses in table 1.
- R7: Select value 3 gives hit=0 for every window, with all other outputs at 0.
- R8: On a hit, the code output equals select×8 + index. This makes the code values distinct across the tables for the same codeword.
- R9: The outputs follow a change of the inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| win_i | input | 6 | Left-aligned bit window; bit 5 is the first stream bit |
| tsel_i | input | 2 | Table select: 0, 1 or 2; 3 is illegal |
| len_o | output | 3 | Length of the matched codeword in bits, 0 on a miss |
| idx_o | output | 3 | Symbol index within the table (0 to 5 common, 6 and 7 private) |
| code_o | output | 5 | Per-table code value: select×8 + index on a hit |
| hit_o | output | 1 | A codeword of the selected table matched |

## Verification
The assertions are evaluated whenever the inputs change. They check the following:
- an illegal select never produces a hit;
- a miss always forces the outputs to zero;
- a window starting with two ones decodes as a three-bit codeword;
- a private index appears only behind a 000 prefix, with a length of five or six;
- every hit reports a length between three and six.

The exact index and length for each codeword of each table can only be shown by the bench's scenarios. The same holds for the distinct code values per table, for each table's own private misses, and for the independence from the trailing window bits. The bench shows that independence by sweeping every free bit.

// File: rtl/merged_cw_lookup.sv
module merged_cw_lookup #(
  parameter int WIN_W   = 6,
  parameter int SEL_W   = 2,
  parameter int TABLES  = 3,
  parameter int N_COM   = 6,
  parameter int N_PRIV  = 2,
  parameter int LEN_W   = 3,
  parameter int IDX_W   = 3
) (
  input  logic [WIN_W-1:0]       win_i,
  input  logic [SEL_W-1:0]       tsel_i,
  output logic [LEN_W-1:0]       len_o,
  output logic [IDX_W-1:0]       idx_o,
  output logic [SEL_W+IDX_W-1:0] code_o,
  output logic                   hit_o
);
  localparam int CODE_W = SEL_W + IDX_W;

  function automatic logic [WIN_W-1:0] len_mask(input int len);
    logic [WIN_W-1:0] ones;
    ones = '1;
    return ones << (WIN_W - len);
  endfunction

  function automatic int com_len(input int e);
    case (e)
      0, 1:    return 3;
      2, 3:    return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic [WIN_W-1:0] com_pat(input int e);
    case (e)
      0:       return WIN_W'(6'b111000);
      1:       return WIN_W'(6'b110000);
      2:       return WIN_W'(6'b010100);
      3:       return WIN_W'(6'b010000);
      4:       return WIN_W'(6'b000110);
      default: return WIN_W'(6'b000100);
    endcase
  endfunction

  function automatic int priv_len(input int t, input int e);
    case (t)
      0:       return 6;
      1:       return (e == 0) ? 5 : 6;
      default: return 5;
    endcase
  endfunction

  function automatic logic [WIN_W-1:0] priv_pat(input int t, input int e);
    case (t)
      0:       return (e == 0) ? WIN_W'(6'b000011) : WIN_W'(6'b000001);
      1:       return (e == 0) ? WIN_W'(6'b000010) : WIN_W'(6'b000000);
      default: return (e == 0) ? WIN_W'(6'b000000) : WIN_W'(6'b000010);
    endcase
  endfunction

  logic              legal;
  logic [N_COM-1:0]  com_hit;
  logic [N_PRIV-1:0] priv_hit [TABLES];

  assign legal = (int'(tsel_i) < TABLES);

  genvar e, t;
  generate
    for (e = 0; e < N_COM; e++) begin : g_com
      localparam logic [WIN_W-1:0] M = len_mask(com_len(e));
      assign com_hit[e] = ((win_i & M) == (com_pat(e) & M));
    end
    for (t = 0; t < TABLES; t++) begin : g_tab
      for (e = 0; e < N_PRIV; e++) begin : g_ent
        localparam logic [WIN_W-1:0] M = len_mask(priv_len(t, e));
        assign priv_hit[t][e] = ((win_i & M) == (priv_pat(t, e) & M));
      end
    end
  endgenerate

  always_comb begin
    hit_o = 1'b0;
    len_o = '0;
    idx_o = '0;
    if (legal) begin
      for (int i = 0; i < N_COM; i++) begin
        if (com_hit[i]) begin
          hit_o = 1'b1;
          len_o = LEN_W'(com_len(i));
          idx_o = IDX_W'(i);
        end
      end
      for (int k = 0; k < TABLES; k++) begin
        if (int'(tsel_i) == k) begin
          for (int j = 0; j < N_PRIV; j++) begin
            if (priv_hit[k][j]) begin
              hit_o = 1'b1;
              len_o = LEN_W'(priv_len(k, j));
              idx_o = IDX_W'(N_COM + j);
            end
          end
        end
      end
    end
  end

  assign code_o = hit_o ? {tsel_i, idx_o} : CODE_W'(0);
endmodule

module merged_cw_lookup_chk #(
  parameter int WIN_W  = 6,
  parameter int SEL_W  = 2,
  parameter int TABLES = 3,
  parameter int LEN_W  = 3,
  parameter int IDX_W  = 3
) (
  input logic [WIN_W-1:0]       win_i,
  input logic [SEL_W-1:0]       tsel_i,
  input logic [LEN_W-1:0]       len_o,
  input logic [IDX_W-1:0]       idx_o,
  input logic [SEL_W+IDX_W-1:0] code_o,
  input logic                   hit_o
);
  always_comb begin
    if (!$isunknown({win_i, tsel_i})) begin
      // R7
      illegal_sel_chk: assert (int'(tsel_i) < TABLES || !hit_o);
      // R6
      miss_zero_chk: assert (hit_o || (len_o == '0 && idx_o == '0 && code_o == '0));
      // R1
      top_pair_chk: assert (!(int'(tsel_i) < TABLES && win_i[WIN_W-1 -: 2] == 2'b11)
                            || (hit_o && len_o == LEN_W'(3) && idx_o == IDX_W'(win_i[WIN_W-3] ? 0 : 1)));
      // R2
      priv_prefix_chk: assert (!(hit_o && idx_o >= IDX_W'(6))
                               || (win_i[WIN_W-1 -: 3] == 3'b000 && len_o >= LEN_W'(5)));
      // R1
      len_range_chk: assert (!hit_o || (len_o >= LEN_W'(3) && len_o <= LEN_W'(6)));
    end
  end
endmodule

bind merged_cw_lookup merged_cw_lookup_chk #(
  .WIN_W(WIN_W), .SEL_W(SEL_W), .TABLES(TABLES), .LEN_W(LEN_W), .IDX_W(IDX_W)
) u_chk (
  .win_i(win_i), .tsel_i(tsel_i), .len_o(len_o), .idx_o(idx_o),
  .code_o(code_o), .hit_o(hit_o)
);

// File: tb/merged_cw_lookup_bench.sv
module merged_cw_lookup_bench;
  logic       clk = 1'b0;
  logic [5:0] win;
  logic [1:0] tsel;
  logic [2:0] len;
  logic [2:0] idx;
  logic [4:0] code;
  logic       hit;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  merged_cw_lookup u_merged_cw_lookup (
    .win_i(win), .tsel_i(tsel), .len_o(len), .idx_o(idx), .code_o(code), .hit_o(hit)
  );

  task automatic apply(input logic [1:0] s, input logic [5:0] w);
    @(negedge clk);
    tsel = s;
    win  = w;
    #1;
  endtask

  task automatic expect_out(input string req, input logic eh, input int el, input int ei);
    int ec;
    ec = eh ? (int'(tsel) * 8 + ei) : 0;
    checks++;
    if (hit !== eh || (eh && (int'(len) != el || int'(idx) != ei)) ||
        (!eh && (len !== 3'd0 || idx !== 3'd0)) || int'(code) != ec) begin
      errors++;
      $display("FAIL %s: tsel=%0d win=%b got hit=%b len=%0d idx=%0d code=%0d exp hit=%b len=%0d idx=%0d code=%0d",
               req, tsel, win, hit, len, idx, code, eh, eh ? el : 0, eh ? ei : 0, ec);
    end
  endtask

  task automatic test_common;
    logic [5:0] pats [6] = '{6'b111000, 6'b110000, 6'b010100, 6'b010000, 6'b000110, 6'b000100};
    int lens [6] = '{3, 3, 4, 4, 5, 5};
    for (int s = 0; s < 3; s++)
      for (int e = 0; e < 6; e++) begin
        apply(2'(s), pats[e]);
        expect_out(s == 0 ? "R1" : "R8", 1'b1, lens[e], e);
      end
  endtask

  task automatic test_t0;
    apply(2'd0, 6'b000011); expect_out("R2", 1'b1, 6, 6);
    apply(2'd0, 6'b000001); expect_out("R2", 1'b1, 6, 7);
  endtask

  task automatic test_t1;
    apply(2'd1, 6'b000010); expect_out("R3", 1'b1, 5, 6);
    apply(2'd1, 6'b000011); expect_out("R3", 1'b1, 5, 6);
    apply(2'd1, 6'b000000); expect_out("R3", 1'b1, 6, 7);
  endtask

  task automatic test_t2;
    apply(2'd2, 6'b000000); expect_out("R4", 1'b1, 5, 6);
    apply(2'd2, 6'b000010); expect_out("R4", 1'b1, 5, 7);
    apply(2'd2, 6'b000011); expect_out("R4", 1'b1, 5, 7);
  endtask

  task automatic test_dontcare;
    for (int f = 0; f < 8; f++) begin
      apply(2'd0, {3'b111, 3'(f)}); expect_out("R5", 1'b1, 3, 0);
      apply(2'd1, {3'b110, 3'(f)}); expect_out("R5", 1'b1, 3, 1);
    end
    for (int f = 0; f < 4; f++) begin
      apply(2'd2, {4'b0101, 2'(f)}); expect_out("R5", 1'b1, 4, 2);
    end
    for (int f = 0; f < 2; f++) begin
      apply(2'd0, {5'b00011, 1'(f)}); expect_out("R5", 1'b1, 5, 4);
    end
  endtask

  task automatic test_miss;
    apply(2'd0, 6'b000010); expect_out("R6", 1'b0, 0, 0);
    apply(2'd0, 6'b000000); expect_out("R6", 1'b0, 0, 0);
    apply(2'd1, 6'b000001); expect_out("R6", 1'b0, 0, 0);
  endtask

  task automatic test_illegal;
    for (int w = 0; w < 64; w++) begin
      apply(2'd3, 6'(w));
      expect_out("R7", 1'b0, 0, 0);
    end
  endtask

  task automatic test_comb;
    tsel = 2'd2; win = 6'b000100;
    #0.5;
    tsel = 2'd0; win = 6'b000001;
    #0.5;
    expect_out("R9", 1'b1, 6, 7);
  endtask

  initial begin
    win = '0;
    tsel = 2'd3;
    #1;
    expect_out("R7", 1'b0, 0, 0);
    test_common;
    test_t0;
    test_t1;
    test_t2;
    test_dontcare;
    test_miss;
    test_illegal;
    test_comb;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule